// File: doc/BRIEF.md
# Unaligned Halfword Access Adapter

This block sits between a processor port that issues byte and 16-bit loads and stores at any byte address and a memory whose locations are each 16 bits wide and addressed by word. The memory is still presented to the processor as byte-addressable. The adapter turns each accepted request into zero, one or two memory word cycles. It drives per-byte write enables, routes write bytes onto the correct lanes, and assembles read data from one or two memory words. The result is returned with a single-cycle done pulse.

A 16-bit access whose byte address is odd crosses a word boundary. A mode input chooses how such an access is handled. When misaligned support is on, the access is split into two word cycles whose halves are merged. When it is off, the access is rejected with a bus fault and touches no memory. Byte order is little-endian throughout. The memory is synchronous: it samples address, enables and write data on the clock edge where `mem_en_o` is high, and presents read data during the following cycle.

Top module: `halfword_align_adapter`

## Requirements
- R1: After reset, and until a request arrives, `req_ready_o` is 1 and `rsp_done_o`, `rsp_fault_o` and `mem_en_o` are 0.
- R2: A byte read (`req_size_i`=0) makes one memory read of word `addr>>1`. It returns the low lane (bits 7:0) for an even address and the high lane (bits 15:8) for an odd address, in bits 7:0 of `rsp_rdata_o` with bits 15:8 zero.
- R3: A byte write makes one memory cycle with `mem_be_o`=01 for an even address or 10 for an odd address. The other byte of that word is left unchanged.
- R4: A halfword read (`req_size_i`=1) at an even address makes one memory read of word `addr>>1`. It returns the whole word, which equals {byte at addr+1, byte at addr}.
- R5: A halfword write at an even address makes one memory cycle with `mem_be_o`=11. `req_wdata_i[7:0]` goes to byte addr and `req_wdata_i[15:8]` goes to byte addr+1.
- R6: With `mis_en_i`=1, a halfword read at an odd address reads word `addr>>1` and then the next word, wrapping to word 0 at the top of the address space. It returns {low byte of the second word, high byte of the first word}.
- R7: With `mis_en_i`=1, a halfword write at an odd address makes two cycles. The first uses `mem_be_o`=10 and carries `req_wdata_i[7:0]`; the second goes to the next word with `mem_be_o`=01 and carries `req_wdata_i[15:8]`. Neighbouring bytes are unchanged.
- R8: With `mis_en_i`=0, a halfword access at an odd address makes no memory cycle. One cycle after acceptance, `rsp_done_o` and `rsp_fault_o` are both 1 and `rsp_rdata_o` is 0. Memory is left unchanged.
- R9: `rsp_done_o` is a one-cycle pulse in the cycle after the last memory cycle. It therefore comes 2 cycles after acceptance for a single-cycle access and 3 cycles after acceptance for a split access.
- R10: `req_ready_o` is 0 from the cycle after acceptance through the done cycle, and is 1 again in the cycle after done.
- R11: `rsp_rdata_o` is 0 in every cycle where `rsp_done_o` is 0, and in the done cycle of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mis_en_i | input | 1 | 1: split odd-address halfword accesses; 0: fault them |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Adapter can accept a request |
| req_we_i | input | 1 | 1 write, 0 read |
| req_size_i | input | 1 | 0 byte, 1 halfword |
| req_addr_i | input | AW | Byte address |
| req_wdata_i | input | 16 | Write data; byte writes use bits 7:0 |
| rsp_done_o | output | 1 | Request completed (one-cycle pulse) |
| rsp_fault_o | output | 1 | Completed request was rejected |
| rsp_rdata_o | output | 16 | Read result, valid with done |
| mem_en_o | output | 1 | Memory cycle this clock |
| mem_we_o | output | 1 | Memory cycle is a write |
| mem_be_o | output | 2 | Byte lane enables (bit 0 = bits 7:0) |
| mem_addr_o | output | AW-1 | Word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid the cycle after a read cycle |

## Verification
Byte accesses are tried at both an even and an odd address, so a swapped lane select or a missing zero-extension shows up at once. Aligned halfword reads and writes are compared against misaligned ones on the same neighbourhood of memory. This separates the single-word path from the split path, and the merge order from the byte-enable order. The same odd-address halfword is issued with the mode both on and off, which tells splitting apart from faulting. An access at the last byte address shows whether the second word wraps to word 0. Cycle counts from acceptance to done and the number of memory cycles are checked for every pattern.

// File: rtl/hw_adapt_pkg.sv
package hw_adapt_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = DATA_W / BYTE_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM0 = 2'd1,
    ST_MEM1 = 2'd2,
    ST_RESP = 2'd3
  } state_e;

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_HALF = 1'b1
  } size_e;
endpackage

// File: rtl/hw_adapt_ctrl.sv
module hw_adapt_ctrl
  import hw_adapt_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   accept_i,
  input  logic   reject_i,
  input  logic   split_q_i,
  output state_e state_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_i) state_d = reject_i ? ST_RESP : ST_MEM0;
      ST_MEM0: state_d = split_q_i ? ST_MEM1 : ST_RESP;
      ST_MEM1: state_d = ST_RESP;
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/hw_adapt_lane_map.sv
module hw_adapt_lane_map
  import hw_adapt_pkg::*;
#(
  parameter int unsigned AW = 16,
  localparam int unsigned WA = AW - 1
) (
  input  logic [AW-1:0]     addr_i,
  input  size_e             size_i,
  input  logic              second_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [WA-1:0]     word_o,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic [WA-1:0] base_word;
  assign base_word = addr_i[AW-1:1];
  // second half of a split goes to the next word, wrapping at the top
  assign word_o = base_word + {{(WA-1){1'b0}}, second_i};

  always_comb begin
    if (size_i == SZ_BYTE) begin
      be_o    = addr_i[0] ? 2'b10 : 2'b01;
      wdata_o = {wdata_i[7:0], wdata_i[7:0]};
    end else if (!addr_i[0]) begin
      be_o    = 2'b11;
      wdata_o = wdata_i;
    end else if (!second_i) begin
      be_o    = 2'b10;
      wdata_o = {wdata_i[7:0], 8'h00};
    end else begin
      be_o    = 2'b01;
      wdata_o = {8'h00, wdata_i[15:8]};
    end
  end
endmodule

// File: rtl/hw_adapt_rd_merge.sv
module hw_adapt_rd_merge
  import hw_adapt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_lo_i,
  input  logic              resp_i,
  input  logic              fault_i,
  input  logic              we_i,
  input  size_e             size_i,
  input  logic              odd_i,
  input  logic              split_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] lo_q;

  // first word of a split read arrives while the second cycle is issued
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lo_q <= '0;
    else if (cap_lo_i) lo_q <= mem_rdata_i[15:8];
  end

  always_comb begin
    rdata_o = '0;
    if (resp_i && !fault_i && !we_i) begin
      if (split_i)               rdata_o = {mem_rdata_i[7:0], lo_q};
      else if (size_i == SZ_HALF) rdata_o = mem_rdata_i;
      else if (odd_i)            rdata_o = {8'h00, mem_rdata_i[15:8]};
      else                       rdata_o = {8'h00, mem_rdata_i[7:0]};
    end
  end
endmodule

// File: rtl/halfword_align_adapter.sv
module halfword_align_adapter
  import hw_adapt_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mis_en_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic          req_size_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [15:0]   req_wdata_i,
  output logic          rsp_done_o,
  output logic          rsp_fault_o,
  output logic [15:0]   rsp_rdata_o,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic [1:0]    mem_be_o,
  output logic [AW-2:0] mem_addr_o,
  output logic [15:0]   mem_wdata_o,
  input  logic [15:0]   mem_rdata_i
);
  state_e            state;
  logic              accept, misaligned, reject;
  logic [AW-1:0]     addr_q;
  logic              we_q, split_q, fault_q;
  size_e             size_q;
  logic [DATA_W-1:0] wdata_q;

  assign req_ready_o = (state == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign misaligned  = req_size_i && req_addr_i[0];
  assign reject      = misaligned && !mis_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      size_q  <= SZ_BYTE;
      wdata_q <= '0;
      split_q <= 1'b0;
      fault_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr_i;
      we_q    <= req_we_i;
      size_q  <= size_e'(req_size_i);
      wdata_q <= req_wdata_i;
      split_q <= misaligned && mis_en_i;
      fault_q <= reject;
    end
  end

  hw_adapt_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .reject_i  (reject),
    .split_q_i (split_q),
    .state_o   (state)
  );

  hw_adapt_lane_map #(.AW(AW)) u_lane (
    .addr_i   (addr_q),
    .size_i   (size_q),
    .second_i (state == ST_MEM1),
    .wdata_i  (wdata_q),
    .word_o   (mem_addr_o),
    .be_o     (mem_be_o),
    .wdata_o  (mem_wdata_o)
  );

  hw_adapt_rd_merge u_merge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_lo_i    (state == ST_MEM1),
    .resp_i      (state == ST_RESP),
    .fault_i     (fault_q),
    .we_i        (we_q),
    .size_i      (size_q),
    .odd_i       (addr_q[0]),
    .split_i     (split_q),
    .mem_rdata_i (mem_rdata_i),
    .rdata_o     (rsp_rdata_o)
  );

  assign mem_en_o    = (state == ST_MEM0) || (state == ST_MEM1);
  assign mem_we_o    = mem_en_o && we_q;
  assign rsp_done_o  = (state == ST_RESP);
  assign rsp_fault_o = rsp_done_o && fault_q;
endmodule

// File: rtl/hw_adapt_checker.sv
module hw_adapt_checker #(
  parameter int unsigned AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          rsp_done_o,
  input logic          rsp_fault_o,
  input logic [15:0]   rsp_rdata_o,
  input logic          mem_en_o,
  input logic [1:0]    mem_be_o,
  input logic [AW-2:0] mem_addr_o
);
  AST_FAULT_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> rsp_done_o);  // R8
  AST_FAULT_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> !$past(mem_en_o));  // R8
  AST_DONE_AFTER_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_done_o && !rsp_fault_o) |-> $past(mem_en_o));  // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);  // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o || rsp_done_o) |-> !req_ready_o);  // R10
  AST_IDLE_RDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_done_o |-> (rsp_rdata_o == 16'h0000));  // R11
  AST_BE_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> (mem_be_o != 2'b00));  // R3
  AST_SPLIT_NEXT_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && $past(mem_en_o)) |-> (mem_addr_o == $past(mem_addr_o) + 1'b1));  // R6
endmodule

bind halfword_align_adapter hw_adapt_checker #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rsp_done_o  (rsp_done_o),
  .rsp_fault_o (rsp_fault_o),
  .rsp_rdata_o (rsp_rdata_o),
  .mem_en_o    (mem_en_o),
  .mem_be_o    (mem_be_o),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/halfword_align_adapter_test.sv
module halfword_align_adapter_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mis_en = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_we = 1'b0;
  logic          req_size = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic          rsp_done, rsp_fault;
  logic [15:0]   rsp_rdata;
  logic          mem_en, mem_we;
  logic [1:0]    mem_be;
  logic [AW-2:0] mem_addr;
  logic [15:0]   mem_wdata;
  logic [15:0]   mem_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] mem_q [32];
  logic [7:0]  ref_b [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  halfword_align_adapter #(.AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mis_en_i(mis_en),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_size_i(req_size), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_done_o(rsp_done), .rsp_fault_o(rsp_fault), .rsp_rdata_o(rsp_rdata),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_be_o(mem_be),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  // synchronous memory model
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        if (mem_be[0]) mem_q[mem_addr[4:0]][7:0]  <= mem_wdata[7:0];
        if (mem_be[1]) mem_q[mem_addr[4:0]][15:8] <= mem_wdata[15:8];
      end else begin
        mem_rdata <= mem_q[mem_addr[4:0]];
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_mem(input string req);
    int bad = 0;
    for (int i = 0; i < 32; i++)
      if (mem_q[i] !== {ref_b[2*i+1], ref_b[2*i]}) bad++;
    chk(req, "memory image mismatches", bad, 0);
  endtask

  // issue one request; report cycles to done, memory cycle count and lanes
  task automatic run_req(input logic we, input logic sz, input logic [AW-1:0] a,
                         input logic [15:0] wd, input string req,
                         output logic [15:0] rd, output logic flt, output int cyc,
                         output int nmem, output logic [1:0] be0, output logic [1:0] be1,
                         output logic [AW-2:0] wa0, output logic [AW-2:0] wa1);
    int busy_ready = 0;
    cyc = 0; nmem = 0; be0 = 0; be1 = 0; wa0 = 0; wa1 = 0;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (1) begin
      cyc++;
      if (req_ready) busy_ready++;
      if (mem_en) begin
        if (nmem == 0) begin be0 = mem_be; wa0 = mem_addr; end
        else           begin be1 = mem_be; wa1 = mem_addr; end
        nmem++;
      end
      if (rsp_done || cyc > 8) break;
      chk("R11", "rdata while not done", rsp_rdata, 0);
      @(negedge clk);
    end
    rd = rsp_rdata; flt = rsp_fault;
    chk("R10", "ready high while busy", busy_ready, 0);
    @(negedge clk);
    chk("R10", "ready after done", req_ready, 1);
    chk("R9", "done not a pulse", rsp_done, 0);
  endtask

  task automatic t_reset;
    chk("R1", "ready", req_ready, 1);
    chk("R1", "done", rsp_done, 0);
    chk("R1", "fault", rsp_fault, 0);
    chk("R1", "mem_en", mem_en, 0);
  endtask

  task automatic t_byte_read;
    logic [15:0] rd; logic f; int c, m; logic [1:0] b0, b1; logic [AW-2:0] w0, w1;
    run_req(0, 0, 16'h0014, 0, "R2", rd, f, c, m, b0, b1, w0, w1);
    chk("R2", "even byte data", rd, {8'h00, ref_b[20]});
    chk("R2", "even byte word", w0, 10);
    chk("R2", "mem cycles", m, 1);
    run_req(0, 0, 16'h0015, 0, "R2", rd, f, c, m, b0, b1, w0, w1);
    chk("R2", "odd byte data", rd, {8'h00, ref_b[21]});
    chk("R9", "byte read latency", c, 2);
  endtask

  task automatic t_byte_write;
    logic [15:0] rd; logic f; int c, m; logic [1:0] b0, b1; logic [AW-2:0] w0, w1;
    run_req(1, 0, 16'h0008, 16'h00C1, "R3", rd, f, c, m, b0, b1, w0, w1);
    ref_b[8] = 8'hC1;
    chk("R3", "even be", b0, 2'b01);
    chk("R11", "write rdata", rd, 0);
    chk_mem("R3");
    run_req(1, 0, 16'h000B, 16'h77D2, "R3", rd, f, c, m, b0, b1, w0, w1);
    ref_b[11] = 8'hD2;
    chk("R3", "odd be", b0, 2'b10);
    chk("R3", "mem cycles", m, 1);
    chk_mem("R3");
  endtask

  task automatic t_half_aligned;
    logic [15:0] rd; logic f; int c, m; logic [1:0] b0, b1; logic [AW-2:0] w0, w1;
    run_req(0, 1, 16'h001C, 0, "R4", rd, f, c, m, b0, b1, w0, w1);
    chk("R4", "aligned half data", rd, {ref_b[29], ref_b[28]});
    chk("R4", "mem cycles", m, 1);
    chk("R9", "aligned latency", c, 2);
    run_req(1, 1, 16'h0020, 16'hBEEF, "R5", rd, f, c, m, b0, b1, w0, w1);
    ref_b[32] = 8'hEF; ref_b[33] = 8'hBE;
    chk("R5", "aligned be", b0, 2'b11);
    chk("R5", "word", w0, 16);
    chk_mem("R5");
  endtask

  task automatic t_half_split;
    logic [15:0] rd; logic f; int c, m; logic [1:0] b0, b1; logic [AW-2:0] w0, w1;
    mis_en = 1'b1;
    run_req(0, 1, 16'h0011, 0, "R6", rd, f, c, m, b0, b1, w0, w1);
    chk("R6", "split read data", rd, {ref_b[18], ref_b[17]});
    chk("R6", "mem cycles", m, 2);
    chk("R6", "first word", w0, 8);
    chk("R6", "second word", w1, 9);
    chk("R9", "split latency", c, 3);
    chk("R6", "no fault", f, 0);
    run_req(1, 1, 16'h0025, 16'h3C4B, "R7", rd, f, c, m, b0, b1, w0, w1);
    ref_b[37] = 8'h4B; ref_b[38] = 8'h3C;
    chk("R7", "first be", b0, 2'b10);
    chk("R7", "second be", b1, 2'b01);
    chk("R7", "mem cycles", m, 2);
    chk_mem("R7");
    // wrap: last byte address pairs with byte 0
    run_req(0, 1, 16'hFFFF, 0, "R6", rd, f, c, m, b0, b1, w0, w1);
    chk("R6", "wrap data", rd, {ref_b[0], ref_b[63]});
    chk("R6", "wrap second word", w1, 0);
  endtask

  task automatic t_fault;
    logic [15:0] rd; logic f; int c, m; logic [1:0] b0, b1; logic [AW-2:0] w0, w1;
    mis_en = 1'b0;
    run_req(0, 1, 16'h0011, 0, "R8", rd, f, c, m, b0, b1, w0, w1);
    chk("R8", "fault flag", f, 1);
    chk("R8", "rdata zero", rd, 0);
    chk("R8", "mem cycles", m, 0);
    chk("R8", "latency", c, 1);
    run_req(1, 1, 16'h0031, 16'h1234, "R8", rd, f, c, m, b0, b1, w0, w1);
    chk("R8", "write fault", f, 1);
    chk("R8", "write mem cycles", m, 0);
    chk_mem("R8");
    // aligned and byte accesses still work with mode off
    run_req(0, 1, 16'h0012, 0, "R4", rd, f, c, m, b0, b1, w0, w1);
    chk("R4", "aligned with mode off", rd, {ref_b[19], ref_b[18]});
    chk("R4", "no fault", f, 0);
    mis_en = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      mem_q[i] = 16'(i * 16'h1357) ^ 16'hA5C3;
      ref_b[2*i]   = mem_q[i][7:0];
      ref_b[2*i+1] = mem_q[i][15:8];
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_byte_read();
    t_byte_write();
    t_half_aligned();
    t_half_split();
    t_fault();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule